// File: doc/BRIEF.md
# Serial ATA Link Power State Controller

This block governs the power state of the link on one serial ATA port. Software writes a 4-bit power command together with two control bits. A legal command becomes a request to the link layer to move the link to the active, partial or slumber state. The link layer answers with accept, reject or done. The command field clears itself back to zero once the request ends. While the field is non-zero, a state change is in progress and further commands are not taken.

With the automatic-entry bit set, the block watches two inputs. One flags an empty command-issued bitmap and the other an empty native-queue bitmap. When both become empty while the link is active and idle, the block requests a low-power state by itself. The deep-select bit picks slumber (1) or partial (0). Requests that the current link state already satisfies, reserved values, and low-power commands made while automatic entry is enabled all leave the field at zero and never reach the link.

Top module: `sata_lpm_ctrl`

## Requirements
- R1: After reset the link state reads active (0), the command field reads 0, both control bits read 0 and no link request is raised.
- R2: Command encodings are 1 = active, 2 = partial and 6 = slumber, and link state codes are 0 = active, 1 = partial and 2 = slumber. A legal write while the field is 0 loads the field. From the next cycle it raises `lreq_valid_o` with the target code, and it holds both until the link responds.
- R3: Response codes are 0 = none, 1 = accept, 2 = reject and 3 = done. A done response moves the link state to the target and clears the field in the same clock edge.
- R4: A reject response leaves the link state unchanged and clears the field.
- R5: A command for the state the link is already in raises no request, and the field reads 0 on the next cycle.
- R6: A write of any value other than 0, 1, 2 or 6 is discarded, and the field reads 0 on the next cycle.
- R7: While the field is non-zero, the command part of any write is ignored. The field and the requested target stay unchanged, and the control bits still update.
- R8: A write of 2 or 6 is ignored when the automatic-entry bit is 1. The value checked is the one carried by the same write.
- R9: With automatic entry enabled, a rise of "both bitmaps empty" while the link is active and no request is pending starts a request. The field reads 6 and the target is slumber when deep-select is 1; otherwise they are 2 and partial. This request takes priority over a write in the same cycle.
- R10: Automatic entry fires once per rise of the empty condition, and never while the link is not active.
- R11: An accept response drops `lreq_valid_o` but keeps the field non-zero until a done or reject arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_cmd_i | input | 4 | Power command written |
| wr_auto_en_i | input | 1 | Automatic low-power entry enable written |
| wr_auto_deep_i | input | 1 | Automatic target select written (1 slumber, 0 partial) |
| rd_cmd_o | output | 4 | Current command field |
| rd_auto_en_o | output | 1 | Stored automatic entry enable |
| rd_auto_deep_o | output | 1 | Stored automatic target select |
| cmd_empty_i | input | 1 | Command-issued bitmap is zero |
| queue_empty_i | input | 1 | Native-queue-active bitmap is zero |
| lreq_valid_o | output | 1 | Link state change request pending |
| lreq_state_o | output | 2 | Requested link state code |
| lrsp_i | input | 2 | Link layer response code |
| link_state_o | output | 2 | Current link state code |

## Verification
The bench targets requests for the current state, reserved codes and low-power writes under automatic mode. A design that got these wrong would raise a spurious link request or leave the field non-zero, and a later command would then lock out. It also drives the accept-then-done path and a reject. Holding state on accept or changing state on reject would show up as a wrong `link_state_o`. Automatic entry is exercised in both target modes, with bitmaps that stay empty, with the link already in low power, and with a write during a busy request. A design that used a level instead of an edge would re-request, and one that accepted a write while busy would corrupt the pending target.

// File: rtl/sata_lpm_pkg.sv
package sata_lpm_pkg;
  localparam int CMD_W = 4;
  localparam int LS_W  = 2;
  localparam int RSP_W = 2;

  localparam logic [CMD_W-1:0] CMD_IDLE = 4'h0;
  localparam logic [CMD_W-1:0] CMD_ACT  = 4'h1;
  localparam logic [CMD_W-1:0] CMD_PART = 4'h2;
  localparam logic [CMD_W-1:0] CMD_SLUM = 4'h6;

  localparam logic [LS_W-1:0] LS_ACTIVE  = 2'd0;
  localparam logic [LS_W-1:0] LS_PARTIAL = 2'd1;
  localparam logic [LS_W-1:0] LS_SLUMBER = 2'd2;

  localparam logic [RSP_W-1:0] RSP_NONE   = 2'd0;
  localparam logic [RSP_W-1:0] RSP_ACCEPT = 2'd1;
  localparam logic [RSP_W-1:0] RSP_REJECT = 2'd2;
  localparam logic [RSP_W-1:0] RSP_DONE   = 2'd3;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT} seq_e;
endpackage

// File: rtl/lpm_cmd_decode.sv
module lpm_cmd_decode
  import sata_lpm_pkg::*;
(
  input  logic             wr_en_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             auto_en_i,
  input  logic             busy_i,
  input  logic [LS_W-1:0]  cur_i,
  output logic             start_o,
  output logic [LS_W-1:0]  tgt_o
);
  logic legal, low_pwr, blocked;

  always_comb begin
    legal = 1'b1;
    tgt_o = LS_ACTIVE;
    case (cmd_i)
      CMD_ACT:  tgt_o = LS_ACTIVE;
      CMD_PART: tgt_o = LS_PARTIAL;
      CMD_SLUM: tgt_o = LS_SLUMBER;
      default:  legal = 1'b0;
    endcase
    low_pwr = (tgt_o != LS_ACTIVE);
    // low-power commands are illegal while automatic entry is on
    blocked = auto_en_i & low_pwr;
    start_o = wr_en_i & ~busy_i & legal & ~blocked & (tgt_o != cur_i);
  end
endmodule

// File: rtl/lpm_auto_trig.sv
module lpm_auto_trig
  import sata_lpm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_empty_i,
  input  logic             queue_empty_i,
  input  logic             en_i,
  input  logic             deep_i,
  input  logic             armed_i,
  output logic             fire_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [LS_W-1:0]  tgt_o
);
  logic empty, empty_q;

  assign empty = cmd_empty_i & queue_empty_i;

  // resets high so an already-empty port does not fire out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) empty_q <= 1'b1;
    else         empty_q <= empty;
  end

  assign fire_o = empty & ~empty_q & en_i & armed_i;
  assign cmd_o  = deep_i ? CMD_SLUM : CMD_PART;
  assign tgt_o  = deep_i ? LS_SLUMBER : LS_PARTIAL;

  assert_fire_once_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import sata_lpm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CMD_W-1:0] start_cmd_i,
  input  logic [LS_W-1:0]  start_tgt_i,
  input  logic [RSP_W-1:0] rsp_i,
  output logic [CMD_W-1:0] field_o,
  output logic             busy_o,
  output logic             req_valid_o,
  output logic [LS_W-1:0]  req_tgt_o,
  output logic [LS_W-1:0]  link_state_o
);
  seq_e             sq_q;
  logic [CMD_W-1:0] field_q;
  logic [LS_W-1:0]  tgt_q, ls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q    <= SQ_IDLE;
      field_q <= CMD_IDLE;
      tgt_q   <= LS_ACTIVE;
      ls_q    <= LS_ACTIVE;
    end else begin
      case (sq_q)
        SQ_IDLE: if (start_i) begin
          field_q <= start_cmd_i;
          tgt_q   <= start_tgt_i;
          sq_q    <= SQ_REQ;
        end
        SQ_REQ, SQ_WAIT: begin
          if (rsp_i == RSP_ACCEPT) begin
            sq_q <= SQ_WAIT;
          end else if (rsp_i == RSP_REJECT) begin
            sq_q    <= SQ_IDLE;
            field_q <= CMD_IDLE;
          end else if (rsp_i == RSP_DONE) begin
            ls_q    <= tgt_q;
            sq_q    <= SQ_IDLE;
            field_q <= CMD_IDLE;
          end
        end
        default: sq_q <= SQ_IDLE;
      endcase
    end
  end

  assign field_o      = field_q;
  assign busy_o       = (sq_q != SQ_IDLE);
  assign req_valid_o  = (sq_q == SQ_REQ);
  assign req_tgt_o    = tgt_q;
  assign link_state_o = ls_q;

  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && rsp_i == RSP_NONE |=> req_valid_o && $stable(req_tgt_o) && $stable(field_o));
  assert_state_on_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(link_state_o) |-> $past(rsp_i == RSP_DONE));
  assert_clear_on_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (rsp_i == RSP_REJECT || rsp_i == RSP_DONE) |=> field_o == CMD_IDLE && !req_valid_o);
  assert_field_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_o == CMD_IDLE || field_o == CMD_ACT || field_o == CMD_PART || field_o == CMD_SLUM);
  assert_no_start_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
  assert_accept_keeps_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && rsp_i == RSP_ACCEPT |=> !req_valid_o && field_o != CMD_IDLE);
endmodule

// File: rtl/sata_lpm_ctrl.sv
module sata_lpm_ctrl
  import sata_lpm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CMD_W-1:0] wr_cmd_i,
  input  logic             wr_auto_en_i,
  input  logic             wr_auto_deep_i,
  output logic [CMD_W-1:0] rd_cmd_o,
  output logic             rd_auto_en_o,
  output logic             rd_auto_deep_o,
  input  logic             cmd_empty_i,
  input  logic             queue_empty_i,
  output logic             lreq_valid_o,
  output logic [LS_W-1:0]  lreq_state_o,
  input  logic [RSP_W-1:0] lrsp_i,
  output logic [LS_W-1:0]  link_state_o
);
  logic             auto_en_q, auto_deep_q;
  logic             busy, dec_start, auto_fire, start;
  logic [LS_W-1:0]  dec_tgt, auto_tgt, start_tgt, ls;
  logic [CMD_W-1:0] auto_cmd, start_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_en_q   <= 1'b0;
      auto_deep_q <= 1'b0;
    end else if (wr_en_i) begin
      auto_en_q   <= wr_auto_en_i;
      auto_deep_q <= wr_auto_deep_i;
    end
  end

  lpm_cmd_decode u_dec (
    .wr_en_i   (wr_en_i),
    .cmd_i     (wr_cmd_i),
    .auto_en_i (wr_auto_en_i),
    .busy_i    (busy),
    .cur_i     (ls),
    .start_o   (dec_start),
    .tgt_o     (dec_tgt)
  );

  lpm_auto_trig u_auto (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_empty_i   (cmd_empty_i),
    .queue_empty_i (queue_empty_i),
    .en_i          (auto_en_q),
    .deep_i        (auto_deep_q),
    .armed_i       ((ls == LS_ACTIVE) && !busy),
    .fire_o        (auto_fire),
    .cmd_o         (auto_cmd),
    .tgt_o         (auto_tgt)
  );

  // hardware-initiated entry wins over a same-cycle software write
  assign start     = auto_fire | dec_start;
  assign start_cmd = auto_fire ? auto_cmd : wr_cmd_i;
  assign start_tgt = auto_fire ? auto_tgt : dec_tgt;

  lpm_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_cmd_i  (start_cmd),
    .start_tgt_i  (start_tgt),
    .rsp_i        (lrsp_i),
    .field_o      (rd_cmd_o),
    .busy_o       (busy),
    .req_valid_o  (lreq_valid_o),
    .req_tgt_o    (lreq_state_o),
    .link_state_o (ls)
  );

  assign link_state_o   = ls;
  assign rd_auto_en_o   = auto_en_q;
  assign rd_auto_deep_o = auto_deep_q;

  assert_auto_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_auto_en_i && !busy && !auto_fire &&
    (wr_cmd_i == CMD_PART || wr_cmd_i == CMD_SLUM) |=> !lreq_valid_o);
  assert_auto_active_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_fire |-> ls == LS_ACTIVE);
endmodule

// File: tb/sim_sata_lpm_ctrl.sv
module sim_sata_lpm_ctrl;
  import sata_lpm_pkg::*;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0, wr_auto_en = 1'b0, wr_auto_deep = 1'b0;
  logic [3:0] wr_cmd = 4'h0;
  logic [3:0] rd_cmd;
  logic rd_auto_en, rd_auto_deep;
  logic cmd_empty = 1'b0, queue_empty = 1'b0;
  logic lreq_valid;
  logic [1:0] lreq_state, lrsp = 2'd0, link_state;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sata_lpm_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_cmd_i(wr_cmd),
    .wr_auto_en_i(wr_auto_en), .wr_auto_deep_i(wr_auto_deep),
    .rd_cmd_o(rd_cmd), .rd_auto_en_o(rd_auto_en), .rd_auto_deep_o(rd_auto_deep),
    .cmd_empty_i(cmd_empty), .queue_empty_i(queue_empty),
    .lreq_valid_o(lreq_valid), .lreq_state_o(lreq_state), .lrsp_i(lrsp),
    .link_state_o(link_state)
  );

  typedef struct packed {
    logic [3:0] cmd;
    logic       en;
    logic [1:0] rsp;
    logic       req;
    logic [1:0] tgt;
    logic [1:0] st;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{4'h2, 1'b0, RSP_DONE,   1'b1, LS_PARTIAL, LS_PARTIAL},
    '{4'h2, 1'b0, RSP_NONE,   1'b0, LS_PARTIAL, LS_PARTIAL},
    '{4'h6, 1'b0, RSP_REJECT, 1'b1, LS_SLUMBER, LS_PARTIAL},
    '{4'h6, 1'b0, RSP_DONE,   1'b1, LS_SLUMBER, LS_SLUMBER},
    '{4'h3, 1'b0, RSP_NONE,   1'b0, LS_SLUMBER, LS_SLUMBER},
    '{4'h1, 1'b0, RSP_DONE,   1'b1, LS_ACTIVE,  LS_ACTIVE},
    '{4'h1, 1'b0, RSP_NONE,   1'b0, LS_ACTIVE,  LS_ACTIVE},
    '{4'hF, 1'b0, RSP_NONE,   1'b0, LS_ACTIVE,  LS_ACTIVE},
    '{4'h6, 1'b1, RSP_NONE,   1'b0, LS_ACTIVE,  LS_ACTIVE},
    '{4'h2, 1'b0, RSP_DONE,   1'b1, LS_PARTIAL, LS_PARTIAL},
    '{4'h1, 1'b0, RSP_ACCEPT, 1'b1, LS_ACTIVE,  LS_ACTIVE}
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] c, input logic en, input logic deep);
    wr_cmd = c; wr_auto_en = en; wr_auto_deep = deep; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rsp(input logic [1:0] code);
    lrsp = code;
    @(negedge clk);
    lrsp = RSP_NONE;
  endtask

  task automatic set_empty(input logic e);
    cmd_empty = e; queue_empty = e;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    string tag;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1", "link_state", link_state, LS_ACTIVE);
    chk("R1", "field", rd_cmd, 0);
    chk("R1", "lreq_valid", lreq_valid, 0);
    chk("R1", "auto_en", rd_auto_en, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic resv;
      resv = !(VT[i].cmd inside {4'h0, 4'h1, 4'h2, 4'h6});
      if (!VT[i].req && VT[i].en)      tag = "R8";
      else if (!VT[i].req && resv)     tag = "R6";
      else if (!VT[i].req)             tag = "R5";
      else if (VT[i].rsp == RSP_REJECT) tag = "R4";
      else if (VT[i].rsp == RSP_ACCEPT) tag = "R11";
      else                             tag = "R3";
      wr(VT[i].cmd, VT[i].en, 1'b0);
      chk(tag, "field after write", rd_cmd, VT[i].req ? int'(VT[i].cmd) : 0);
      chk(tag, "lreq_valid after write", lreq_valid, VT[i].req);
      if (VT[i].req) begin
        chk("R2", "lreq_state", lreq_state, VT[i].tgt);
        @(negedge clk);
        chk("R2", "request held", lreq_valid, 1);
        if (VT[i].rsp == RSP_ACCEPT) begin
          rsp(RSP_ACCEPT);
          chk("R11", "lreq_valid after accept", lreq_valid, 0);
          chk("R11", "field after accept", rd_cmd, VT[i].cmd);
          @(negedge clk);
          chk("R11", "state before done", link_state, LS_PARTIAL);
          rsp(RSP_DONE);
        end else begin
          rsp(VT[i].rsp);
        end
        chk(tag, "field after response", rd_cmd, 0);
      end else begin
        @(negedge clk);
        chk(tag, "no request later", lreq_valid, 0);
      end
      chk(tag, "link_state", link_state, VT[i].st);
    end

    // R7 busy write ignored
    wr(4'h2, 1'b0, 1'b0);
    wr(4'h6, 1'b0, 1'b1);
    chk("R7", "field while busy", rd_cmd, 2);
    chk("R7", "target while busy", lreq_state, LS_PARTIAL);
    chk("R7", "control bit still written", rd_auto_deep, 1);
    rsp(RSP_DONE);
    chk("R7", "state", link_state, LS_PARTIAL);
    wr(4'h1, 1'b0, 1'b0);
    rsp(RSP_DONE);
    chk("R3", "back to active", link_state, LS_ACTIVE);

    // R9 automatic partial
    wr(4'h0, 1'b1, 1'b0);
    chk("R9", "no-op write leaves field", rd_cmd, 0);
    set_empty(1'b1);
    chk("R9", "auto field partial", rd_cmd, 2);
    chk("R9", "auto request", lreq_valid, 1);
    chk("R9", "auto target partial", lreq_state, LS_PARTIAL);
    rsp(RSP_DONE);
    chk("R9", "state partial", link_state, LS_PARTIAL);

    // R10 no repeat, no fire when not active
    repeat (3) @(negedge clk);
    chk("R10", "no repeat field", rd_cmd, 0);
    chk("R10", "no repeat request", lreq_valid, 0);
    set_empty(1'b0);
    set_empty(1'b1);
    chk("R10", "no fire in low power", rd_cmd, 0);
    chk("R10", "no request in low power", lreq_valid, 0);

    wr(4'h1, 1'b1, 1'b1);
    chk("R8", "active allowed under auto", lreq_valid, 1);
    rsp(RSP_DONE);
    chk("R3", "active again", link_state, LS_ACTIVE);

    // R9 automatic slumber, rejected
    set_empty(1'b0);
    set_empty(1'b1);
    chk("R9", "auto field slumber", rd_cmd, 6);
    chk("R9", "auto target slumber", lreq_state, LS_SLUMBER);
    rsp(RSP_REJECT);
    chk("R4", "reject keeps active", link_state, LS_ACTIVE);
    chk("R4", "reject clears field", rd_cmd, 0);

    // R8 stored auto mode, write of partial ignored
    wr(4'h2, 1'b1, 1'b1);
    chk("R8", "blocked write field", rd_cmd, 0);
    chk("R8", "blocked write request", lreq_valid, 0);

    // R1 reset during a request
    wr(4'h6, 1'b0, 1'b0);
    chk("R2", "request before reset", lreq_valid, 1);
    rst_ni = 1'b0;
    #1;
    chk("R1", "reset field", rd_cmd, 0);
    chk("R1", "reset request", lreq_valid, 0);
    chk("R1", "reset state", link_state, LS_ACTIVE);
    chk("R1", "reset deep", rd_auto_deep, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule